// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces horizontal sync, vertical sync, composite sync and a data-enable strobe for a video raster, together with the current pixel and line position, a field flag and a one-cycle field-start pulse. Horizontal timing is programmed as active width, sync start, sync end and total pixels per line. Vertical timing is programmed as the same four values for one field. In progressive mode every field uses these values unchanged. In interlaced mode fields alternate between an even set, which uses the programmed values, and an odd set that is derived from it.

The odd field is one line longer. Its sync start and sync end lines are one line later, so the gap after the sync pulse to the end of the field stays the same. Its vertical sync edges occur half a line earlier in the line than the even field's edges. Positions count from the top-left active pixel, which is pixel 0 of line 0.

Each sync output has its own polarity control, and its default is active high. The horizontal timing inputs take effect at once. The vertical timing inputs and the interlace choice are captured only when one field ends and the next begins. The timing inputs must hold their values while reset is asserted.

Top module: `ilace_raster_gen`

## Requirements
- R1: `pix_x_o` steps by one per clock and wraps to 0 after `h_total-1`. `line_y_o` steps at each wrap and returns to 0 after the field's last line. Pixel 0 of line 0 is the first active pixel.
- R2: With `interlace_en`=1, fields alternate and the first field after reset is even (`field_o`=0). An even field has `v_total` lines and an odd field (`field_o`=1) has `v_total+1` lines.
- R3: `de_o` is 1 exactly when `pix_x_o < h_active` and `line_y_o < v_active`.
- R4: Horizontal sync is active when `h_sync_beg <= pix_x_o < h_sync_end`.
- R5: On an even field, vertical sync is active from position (line `v_sync_beg`, pixel `h_sync_beg`) up to position (line `v_sync_end`, pixel `h_sync_beg`), in raster order, with the end position excluded.
- R6: On an odd field, vertical sync begins at line `v_sync_beg+1` and ends at line `v_sync_end+1`. Both edges occur at pixel `h_sync_beg - h_total/2` (integer halving).
- R7: Each of `inv_hsync`, `inv_vsync` and `inv_csync` set to 1 makes its output active low. When its bit is 0 the output is active high. Composite sync is active while horizontal or vertical sync is active.
- R8: A change to the vertical timing inputs in the middle of a field has no effect on that field's length. It applies from the next field.
- R9: With `interlace_en`=0, `field_o` stays 0 and every field has `v_total` lines with the even-field sync placement.
- R10: `frame_start_o` is high for exactly one cycle per field, at pixel 0 of line 0.
- R11: While `rst` is high, the pixel and line outputs, `field_o`, `de_o` and `frame_start_o` are 0, and each sync output sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| interlace_en | input | 1 | 1 selects interlaced field alternation |
| h_active | input | HW | Active pixels per line |
| h_sync_beg | input | HW | First pixel of horizontal sync |
| h_sync_end | input | HW | First pixel after horizontal sync |
| h_total | input | HW | Pixels per line |
| v_active | input | VW | Active lines per field |
| v_sync_beg | input | VW | First vertical sync line, even field |
| v_sync_end | input | VW | Line at which vertical sync ends, even field |
| v_total | input | VW | Lines per even field |
| inv_hsync | input | 1 | Makes horizontal sync active low |
| inv_vsync | input | 1 | Makes vertical sync active low |
| inv_csync | input | 1 | Makes composite sync active low |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| de_o | output | 1 | Data enable |
| frame_start_o | output | 1 | Pulse at pixel 0, line 0 of each field |
| field_o | output | 1 | 0 even field, 1 odd field |
| pix_x_o | output | HW | Pixel position of the outputs |
| line_y_o | output | VW | Line position of the outputs |

## Verification
The bench builds the block with the default widths HW=12 and VW=11, which are wide enough for a 2640-pixel, 563-line field. It then programs a small raster: 20 pixels per line and 9 lines in the even field. A full interlaced frame therefore lasts only 380 cycles. This keeps every line wrap and field boundary within a short run, including the odd field's extra line, its shifted vertical sync edges and a vertical update in the middle of a field. Progressive mode and the polarity inversions are each exercised after a fresh reset.

// File: rtl/ilrg_pkg.sv
package ilrg_pkg;
  typedef enum logic {
    FLD_EVEN = 1'b0,
    FLD_ODD  = 1'b1
  } field_e;

  // Field that follows the current one at a boundary
  function automatic field_e next_field(input field_e cur, input logic ilace);
    if (!ilace) return FLD_EVEN;
    return (cur == FLD_EVEN) ? FLD_ODD : FLD_EVEN;
  endfunction
endpackage

// File: rtl/ilrg_field_sel.sv
module ilrg_field_sel #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic [VW-1:0] v_sync_beg,
  input  logic [VW-1:0] v_sync_end,
  input  logic [VW-1:0] v_total,
  input  logic [HW-1:0] h_sync_beg,
  input  logic [HW-1:0] h_total,
  output logic [VW-1:0] ev_vsb,
  output logic [VW-1:0] ev_vse,
  output logic [VW-1:0] ev_vtot,
  output logic [VW-1:0] od_vsb,
  output logic [VW-1:0] od_vse,
  output logic [VW-1:0] od_vtot,
  output logic [HW-1:0] ev_vhp,
  output logic [HW-1:0] od_vhp
);
  localparam logic [VW-1:0] ONE_LINE = VW'(1);

  always_comb begin
    ev_vsb  = v_sync_beg;
    ev_vse  = v_sync_end;
    ev_vtot = v_total;
    // odd field: extra line before sync, same gap after sync
    od_vsb  = v_sync_beg + ONE_LINE;
    od_vse  = v_sync_end + ONE_LINE;
    od_vtot = v_total + ONE_LINE;
    ev_vhp  = h_sync_beg;
    od_vhp  = h_sync_beg - (h_total >> 1);
  end
endmodule

// File: rtl/ilrg_counters.sv
module ilrg_counters
  import ilrg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          interlace_en,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] ev_vsb,
  input  logic [VW-1:0] ev_vse,
  input  logic [VW-1:0] ev_vtot,
  input  logic [VW-1:0] od_vsb,
  input  logic [VW-1:0] od_vse,
  input  logic [VW-1:0] od_vtot,
  output logic [HW-1:0] x_q,
  output logic [VW-1:0] y_q,
  output field_e        field_q,
  output logic [VW-1:0] cur_vsb,
  output logic [VW-1:0] cur_vse,
  output logic [VW-1:0] cur_vtot
);
  logic   line_end;
  logic   field_end;
  field_e nf;

  always_comb begin
    line_end  = (x_q == h_total - HW'(1));
    field_end = line_end && (y_q == cur_vtot - VW'(1));
    nf        = next_field(field_q, interlace_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q      <= '0;
      y_q      <= '0;
      field_q  <= FLD_EVEN;
      cur_vsb  <= ev_vsb;
      cur_vse  <= ev_vse;
      cur_vtot <= ev_vtot;
    end else if (line_end) begin
      x_q <= '0;
      if (field_end) begin
        y_q     <= '0;
        field_q <= nf;
        // vertical set is captured only here
        if (nf == FLD_ODD) begin
          cur_vsb  <= od_vsb;
          cur_vse  <= od_vse;
          cur_vtot <= od_vtot;
        end else begin
          cur_vsb  <= ev_vsb;
          cur_vse  <= ev_vse;
          cur_vtot <= ev_vtot;
        end
      end else begin
        y_q <= y_q + VW'(1);
      end
    end else begin
      x_q <= x_q + HW'(1);
    end
  end
endmodule

// File: rtl/ilrg_out_stage.sv
module ilrg_out_stage
  import ilrg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] x_q,
  input  logic [VW-1:0] y_q,
  input  field_e        field_q,
  input  logic [VW-1:0] cur_vsb,
  input  logic [VW-1:0] cur_vse,
  input  logic [HW-1:0] ev_vhp,
  input  logic [HW-1:0] od_vhp,
  input  logic [HW-1:0] h_active,
  input  logic [HW-1:0] h_sync_beg,
  input  logic [HW-1:0] h_sync_end,
  input  logic [VW-1:0] v_active,
  input  logic          inv_hsync,
  input  logic          inv_vsync,
  input  logic          inv_csync,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          csync_o,
  output logic          de_o,
  output logic          frame_start_o,
  output logic          field_o,
  output logic [HW-1:0] pix_x_o,
  output logic [VW-1:0] line_y_o
);
  logic [HW-1:0] vhp;
  logic          hs_act, vs_act, past_beg, before_end, de_nx;

  always_comb begin
    vhp        = (field_q == FLD_ODD) ? od_vhp : ev_vhp;
    hs_act     = (x_q >= h_sync_beg) && (x_q < h_sync_end);
    past_beg   = (y_q > cur_vsb) || ((y_q == cur_vsb) && (x_q >= vhp));
    before_end = (y_q < cur_vse) || ((y_q == cur_vse) && (x_q < vhp));
    vs_act     = past_beg && before_end;
    de_nx      = (x_q < h_active) && (y_q < v_active);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o       <= inv_hsync;
      vsync_o       <= inv_vsync;
      csync_o       <= inv_csync;
      de_o          <= 1'b0;
      frame_start_o <= 1'b0;
      field_o       <= 1'b0;
      pix_x_o       <= '0;
      line_y_o      <= '0;
    end else begin
      hsync_o       <= hs_act ^ inv_hsync;
      vsync_o       <= vs_act ^ inv_vsync;
      csync_o       <= (hs_act | vs_act) ^ inv_csync;
      de_o          <= de_nx;
      frame_start_o <= (x_q == '0) && (y_q == '0);
      field_o       <= (field_q == FLD_ODD);
      pix_x_o       <= x_q;
      line_y_o      <= y_q;
    end
  end
endmodule

// File: rtl/ilace_raster_gen.sv
module ilace_raster_gen
  import ilrg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          interlace_en,
  input  logic [HW-1:0] h_active,
  input  logic [HW-1:0] h_sync_beg,
  input  logic [HW-1:0] h_sync_end,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_active,
  input  logic [VW-1:0] v_sync_beg,
  input  logic [VW-1:0] v_sync_end,
  input  logic [VW-1:0] v_total,
  input  logic          inv_hsync,
  input  logic          inv_vsync,
  input  logic          inv_csync,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          csync_o,
  output logic          de_o,
  output logic          frame_start_o,
  output logic          field_o,
  output logic [HW-1:0] pix_x_o,
  output logic [VW-1:0] line_y_o
);
  logic [VW-1:0] ev_vsb, ev_vse, ev_vtot, od_vsb, od_vse, od_vtot;
  logic [HW-1:0] ev_vhp, od_vhp;
  logic [HW-1:0] x_q;
  logic [VW-1:0] y_q;
  field_e        field_q;
  logic [VW-1:0] cur_vsb, cur_vse, cur_vtot;

  ilrg_field_sel #(.HW(HW), .VW(VW)) sel_i (
    .v_sync_beg(v_sync_beg), .v_sync_end(v_sync_end), .v_total(v_total),
    .h_sync_beg(h_sync_beg), .h_total(h_total),
    .ev_vsb(ev_vsb), .ev_vse(ev_vse), .ev_vtot(ev_vtot),
    .od_vsb(od_vsb), .od_vse(od_vse), .od_vtot(od_vtot),
    .ev_vhp(ev_vhp), .od_vhp(od_vhp)
  );

  ilrg_counters #(.HW(HW), .VW(VW)) cnt_i (
    .clk(clk), .rst(rst), .interlace_en(interlace_en), .h_total(h_total),
    .ev_vsb(ev_vsb), .ev_vse(ev_vse), .ev_vtot(ev_vtot),
    .od_vsb(od_vsb), .od_vse(od_vse), .od_vtot(od_vtot),
    .x_q(x_q), .y_q(y_q), .field_q(field_q),
    .cur_vsb(cur_vsb), .cur_vse(cur_vse), .cur_vtot(cur_vtot)
  );

  ilrg_out_stage #(.HW(HW), .VW(VW)) out_i (
    .clk(clk), .rst(rst), .x_q(x_q), .y_q(y_q), .field_q(field_q),
    .cur_vsb(cur_vsb), .cur_vse(cur_vse), .ev_vhp(ev_vhp), .od_vhp(od_vhp),
    .h_active(h_active), .h_sync_beg(h_sync_beg), .h_sync_end(h_sync_end),
    .v_active(v_active), .inv_hsync(inv_hsync), .inv_vsync(inv_vsync),
    .inv_csync(inv_csync), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .csync_o(csync_o), .de_o(de_o), .frame_start_o(frame_start_o),
    .field_o(field_o), .pix_x_o(pix_x_o), .line_y_o(line_y_o)
  );
endmodule

// File: rtl/ilrg_chk.sv
module ilrg_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          interlace_en,
  input logic [HW-1:0] h_active,
  input logic [VW-1:0] v_active,
  input logic          de_o,
  input logic          frame_start_o,
  input logic          field_o,
  input logic [HW-1:0] pix_x_o,
  input logic [VW-1:0] line_y_o
);
  // R3
  de_window_chk: assert property (@(posedge clk) disable iff (rst)
    de_o |-> ((pix_x_o < h_active) && (line_y_o < v_active)));

  // R10
  start_origin_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> ((pix_x_o == '0) && (line_y_o == '0)));

  // R2
  field_flip_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_o) |-> frame_start_o);

  // R9
  prog_field_chk: assert property (@(posedge clk) disable iff (rst)
    (!interlace_en && !field_o) |=> !field_o);

  // R1
  pix_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_x_o != '0) |-> (pix_x_o == $past(pix_x_o) + HW'(1)));
endmodule

bind ilace_raster_gen ilrg_chk #(.HW(HW), .VW(VW)) chk_i (
  .clk(clk), .rst(rst), .interlace_en(interlace_en),
  .h_active(h_active), .v_active(v_active), .de_o(de_o),
  .frame_start_o(frame_start_o), .field_o(field_o),
  .pix_x_o(pix_x_o), .line_y_o(line_y_o)
);

// File: tb/ilace_raster_gen_tb_top.sv
`timescale 1ns/1ps
module ilace_raster_gen_tb_top;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic interlace_en = 1'b1;
  logic [HW-1:0] h_active = 12, h_sync_beg = 14, h_sync_end = 16, h_total = 20;
  logic [VW-1:0] v_active = 4, v_sync_beg = 6, v_sync_end = 7, v_total = 9;
  logic inv_hsync = 0, inv_vsync = 0, inv_csync = 0;
  logic hsync_o, vsync_o, csync_o, de_o, frame_start_o, field_o;
  logic [HW-1:0] pix_x_o;
  logic [VW-1:0] line_y_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ilace_raster_gen #(.HW(HW), .VW(VW)) dut_i (
    .clk(clk), .rst(rst), .interlace_en(interlace_en),
    .h_active(h_active), .h_sync_beg(h_sync_beg), .h_sync_end(h_sync_end),
    .h_total(h_total), .v_active(v_active), .v_sync_beg(v_sync_beg),
    .v_sync_end(v_sync_end), .v_total(v_total), .inv_hsync(inv_hsync),
    .inv_vsync(inv_vsync), .inv_csync(inv_csync), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .csync_o(csync_o), .de_o(de_o),
    .frame_start_o(frame_start_o), .field_o(field_o),
    .pix_x_o(pix_x_o), .line_y_o(line_y_o)
  );

  // field, line, pixel, then expected hsync, vsync, de (active high)
  typedef struct packed {
    logic       fld;
    logic [7:0] y;
    logic [7:0] x;
    logic       hs;
    logic       vs;
    logic       de;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0, 8'd0,  1'b0, 1'b0, 1'b1},
    '{1'b0, 8'd0, 8'd14, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'd0, 8'd15, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'd0, 8'd16, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'd3, 8'd11, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'd3, 8'd12, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'd4, 8'd0,  1'b0, 1'b0, 1'b0},
    '{1'b0, 8'd6, 8'd13, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'd6, 8'd14, 1'b1, 1'b1, 1'b0},
    '{1'b0, 8'd7, 8'd13, 1'b0, 1'b1, 1'b0},
    '{1'b0, 8'd7, 8'd14, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'd8, 8'd19, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd6, 8'd19, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd7, 8'd3,  1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd7, 8'd4,  1'b0, 1'b1, 1'b0},
    '{1'b1, 8'd8, 8'd3,  1'b0, 1'b1, 1'b0},
    '{1'b1, 8'd8, 8'd4,  1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd9, 8'd19, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  // wait at falling edges until the outputs show the given position
  task automatic wait_pos(input int f, input int y, input int x, output bit hit);
    hit = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (field_o == f[0] && int'(line_y_o) == y && int'(pix_x_o) == x) begin
        hit = 1;
        break;
      end
    end
  endtask

  // cycles from one field-start pulse to the next; field seen at start
  task automatic measure(output int n, output int f);
    while (!frame_start_o) @(negedge clk);
    f = field_o;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!frame_start_o && n < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit hit;
    int n, f;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 de in reset", de_o, 0);
    chk("R11 frame_start in reset", frame_start_o, 0);
    chk("R11 field in reset", field_o, 0);
    chk("R11 pixel in reset", pix_x_o, 0);
    chk("R11 line in reset", line_y_o, 0);
    chk("R11 hsync inactive", hsync_o, 0);
    chk("R11 vsync inactive", vsync_o, 0);
    rst = 1'b0;

    // interlaced table walk (R1 R3 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      wait_pos(VECS[i].fld, VECS[i].y, VECS[i].x, hit);
      chk($sformatf("R1/R2 position %0d reached", i), hit, 1);
      chk($sformatf("R4 hsync vec %0d", i), hsync_o, VECS[i].hs);
      chk($sformatf("R5/R6 vsync vec %0d", i), vsync_o, VECS[i].vs);
      chk($sformatf("R3 de vec %0d", i), de_o, VECS[i].de);
      chk($sformatf("R7 csync vec %0d", i), csync_o, VECS[i].hs | VECS[i].vs);
    end

    // R2 alternating field lengths, R10 one pulse per field
    measure(n, f);
    chk("R2 even field cycles", n, 180);
    chk("R2 even field flag", f, 0);
    measure(n, f);
    chk("R2 odd field cycles", n, 200);
    chk("R2 odd field flag", f, 1);
    measure(n, f);
    chk("R10 next field start after odd", n, 180);

    // R9 progressive mode
    interlace_en = 1'b0;
    do_reset();
    measure(n, f);
    chk("R9 progressive field cycles", n, 180);
    measure(n, f);
    chk("R9 progressive second field cycles", n, 180);
    chk("R9 field flag stays 0", f, 0);
    wait_pos(0, 6, 14, hit);
    chk("R9 vsync even placement", vsync_o, 1);
    wait_pos(0, 7, 4, hit);
    chk("R9 no odd-field vsync", vsync_o, 1);
    wait_pos(0, 7, 14, hit);
    chk("R9 vsync ends at even column", vsync_o, 0);

    // R8 mid-field vertical update
    while (!frame_start_o) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 30) v_total = 11;
    end while (!frame_start_o && n < 2000);
    chk("R8 current field unchanged", n, 180);
    measure(n, f);
    chk("R8 next field uses new total", n, 220);
    v_total = 9;

    // R7 polarity inversion
    inv_hsync = 1'b1; inv_vsync = 1'b1; inv_csync = 1'b1;
    interlace_en = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 inverted hsync idle level", hsync_o, 1);
    rst = 1'b0;
    wait_pos(0, 0, 0, hit);
    chk("R7 inverted hsync idle", hsync_o, 1);
    chk("R7 inverted csync idle", csync_o, 1);
    chk("R7 inverted vsync idle", vsync_o, 1);
    wait_pos(0, 0, 14, hit);
    chk("R7 inverted hsync active", hsync_o, 0);
    chk("R7 inverted csync on hsync", csync_o, 0);
    wait_pos(0, 6, 14, hit);
    chk("R7 inverted vsync active", vsync_o, 0);
    wait_pos(0, 7, 13, hit);
    chk("R7 inverted csync on vsync only", csync_o, 0);
    chk("R7 hsync idle during vsync", hsync_o, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule